// File: doc/BRIEF.md
# Multi-Flow Two-Rate Three-Color Policer

This block meters packets for up to sixteen flows. Each flow has two token buckets. The committed bucket refills at the committed rate and the peak bucket at the peak rate, and each bucket is capped at its own burst size. An arriving packet gives its flow index and byte length, and is stamped with the free-running `now` input on the cycle it is accepted. The block does not refill buckets every cycle. Each flow records the tick of its last update, and when a packet of that flow arrives the block credits the elapsed ticks times the rate. It then colours the packet green, yellow or red, writes the new bucket state back and reports the colour with an action: pass, remark to a lower class, or drop.

Packets enter on a valid/ready stream and results leave on a second valid/ready stream, one result per accepted packet and in acceptance order. A packet is taken on any rising edge where `pkt_valid` and `pkt_ready` are both high. A result is consumed on any edge where `res_valid` and `res_ready` are both high. While a result waits with `res_ready` low, the result holds and `pkt_ready` stays low, so the whole pipeline stalls. Rates and burst sizes are loaded through a plain single-cycle configuration write.

Top module: `tcm_policer`

## Requirements
- R1: After reset no result is valid, `pkt_ready` is high, and every flow has empty buckets, so a packet with a nonzero length on an unconfigured flow is red and a zero-length packet is green.
- R2: Each accepted packet produces exactly one result, with `res_flow` equal to its flow. The result becomes valid on the second rising edge after acceptance when not stalled, and results leave in acceptance order.
- R3: While `res_valid` is high and `res_ready` is low, `res_color`, `res_action` and `res_flow` hold their values and `pkt_ready` is low.
- R4: If the peak bucket holds fewer tokens than the length, the packet is red (`res_color`=2) with action drop (`res_action`=2), and neither bucket is debited.
- R5: Otherwise, if the committed bucket holds fewer tokens than the length, the packet is yellow (`res_color`=1) with action remark (`res_action`=1), and only the peak bucket is debited by the length.
- R6: Otherwise the packet is green (`res_color`=0) with action pass (`res_action`=0), and both buckets are debited by the length.
- R7: When a packet is processed, each bucket of its flow first gains (elapsed ticks × rate) tokens. A rate is unsigned fixed point in bytes per tick with 8 fractional bits, and fractional tokens are kept between packets.
- R8: A bucket never exceeds its burst size in bytes. A refill that would pass the burst size leaves the bucket exactly full.
- R9: Elapsed ticks are the difference between the packet's `now` stamp and the flow's last update, taken modulo 2^TS_W, so the stamp may wrap. Every processed packet, red included, makes its stamp the flow's last update.
- R10: A configuration write sets the flow's rates and burst sizes, fills both buckets to their burst sizes and sets the last update to `now`. It takes effect for packets accepted after the write edge. It must not target a flow that has a packet presented or in flight.
- R11: Packets of the same flow accepted on consecutive cycles each see the state left by the one before, not the stored state.
- R12: Flows are independent: a packet changes only the buckets of its own flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| now | input | 16 | Free-running tick count, sampled on packet accept and configuration writes |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Block can take a packet this cycle |
| pkt_flow | input | 4 | Flow index of the offered packet |
| pkt_len | input | 16 | Packet length in bytes |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_flow | output | 4 | Flow index of the result |
| res_color | output | 2 | 0 green, 1 yellow, 2 red |
| res_action | output | 2 | 0 pass, 1 remark, 2 drop |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flow | input | 4 | Flow being configured |
| cfg_cir | input | 16 | Committed rate, bytes per tick, 8 fractional bits |
| cfg_pir | input | 16 | Peak rate, bytes per tick, 8 fractional bits |
| cfg_cbs | input | 20 | Committed burst size in bytes |
| cfg_pbs | input | 20 | Peak burst size in bytes |

## Verification
A wrong bucket value is not visible at the ports when it is written. It shows up as a wrong colour on the next packet of the same flow, which can be many packets later. The directed sequences therefore keep each flow close to a threshold and send lengths that fall just above or just below it. A stale read in the read-modify-write shows as a wrong colour on the second of two back-to-back packets of one flow, two cycles after that packet's acceptance. Refill, saturation and timestamp wrap errors each show on the first packet after a chosen idle gap.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int FRAC_W = 8;
  localparam int NBKT   = 2;
  localparam int BK_C   = 0;
  localparam int BK_P   = 1;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } color_e;

  typedef enum logic [1:0] {
    ACT_PASS   = 2'd0,
    ACT_REMARK = 2'd1,
    ACT_DROP   = 2'd2
  } action_e;
endpackage

// File: rtl/tcm_refill.sv
module tcm_refill import tcm_pkg::*; #(
  parameter int TS_W    = 16,
  parameter int RATE_W  = 16,
  parameter int BURST_W = 20
) (
  input  logic [BURST_W+FRAC_W-1:0] tok,
  input  logic [BURST_W-1:0]        burst,
  input  logic [RATE_W-1:0]         rate,
  input  logic [TS_W-1:0]           elapsed,
  output logic [BURST_W+FRAC_W-1:0] tok_new
);
  localparam int TOK_W  = BURST_W + FRAC_W;
  localparam int PROD_W = TS_W + RATE_W;
  localparam int SUM_W  = ((TOK_W > PROD_W) ? TOK_W : PROD_W) + 1;

  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  sum;
  logic [TOK_W-1:0]  cap;

  // full-width product: no idle gap can overflow before the cap applies
  assign prod    = PROD_W'(elapsed) * PROD_W'(rate);
  assign sum     = SUM_W'(tok) + SUM_W'(prod);
  assign cap     = {burst, {FRAC_W{1'b0}}};
  assign tok_new = (sum > SUM_W'(cap)) ? cap : sum[TOK_W-1:0];
endmodule

// File: rtl/tcm_classify.sv
module tcm_classify import tcm_pkg::*; #(
  parameter int BURST_W = 20,
  parameter int LEN_W   = 16
) (
  input  logic [BURST_W+FRAC_W-1:0] ctok,
  input  logic [BURST_W+FRAC_W-1:0] ptok,
  input  logic [LEN_W-1:0]          len,
  output color_e                    color,
  output action_e                   action,
  output logic [BURST_W+FRAC_W-1:0] ctok_out,
  output logic [BURST_W+FRAC_W-1:0] ptok_out
);
  localparam int TOK_W  = BURST_W + FRAC_W;
  localparam int NEED_W = LEN_W + FRAC_W;
  localparam int CMP_W  = (TOK_W > NEED_W) ? TOK_W : NEED_W;

  logic [NEED_W-1:0] need_fx;
  logic              p_short;
  logic              c_short;

  assign need_fx = {len, {FRAC_W{1'b0}}};
  assign p_short = CMP_W'(ptok) < CMP_W'(need_fx);
  assign c_short = CMP_W'(ctok) < CMP_W'(need_fx);

  always_comb begin
    ctok_out = ctok;
    ptok_out = ptok;
    if (p_short) begin
      color  = COL_RED;
      action = ACT_DROP;
    end else if (c_short) begin
      color    = COL_YELLOW;
      action   = ACT_REMARK;
      ptok_out = ptok - TOK_W'(need_fx);
    end else begin
      color    = COL_GREEN;
      action   = ACT_PASS;
      ptok_out = ptok - TOK_W'(need_fx);
      ctok_out = ctok - TOK_W'(need_fx);
    end
  end
endmodule

// File: rtl/tcm_flow_table.sv
module tcm_flow_table import tcm_pkg::*; #(
  parameter int FLOWS   = 16,
  parameter int RATE_W  = 16,
  parameter int BURST_W = 20,
  parameter int TS_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(FLOWS)-1:0]    cfg_flow,
  input  logic [RATE_W-1:0]           cfg_cir,
  input  logic [RATE_W-1:0]           cfg_pir,
  input  logic [BURST_W-1:0]          cfg_cbs,
  input  logic [BURST_W-1:0]          cfg_pbs,
  input  logic [TS_W-1:0]             cfg_now,
  input  logic                        wb_en,
  input  logic [$clog2(FLOWS)-1:0]    wb_flow,
  input  logic [BURST_W+FRAC_W-1:0]   wb_ctok,
  input  logic [BURST_W+FRAC_W-1:0]   wb_ptok,
  input  logic [TS_W-1:0]             wb_ts,
  input  logic [$clog2(FLOWS)-1:0]    rd_flow,
  output logic [RATE_W-1:0]           rd_cir,
  output logic [RATE_W-1:0]           rd_pir,
  output logic [BURST_W-1:0]          rd_cbs,
  output logic [BURST_W-1:0]          rd_pbs,
  output logic [BURST_W+FRAC_W-1:0]   rd_ctok,
  output logic [BURST_W+FRAC_W-1:0]   rd_ptok,
  output logic [TS_W-1:0]             rd_ts
);
  localparam int TOK_W = BURST_W + FRAC_W;

  logic [RATE_W-1:0]  cir_q  [FLOWS];
  logic [RATE_W-1:0]  pir_q  [FLOWS];
  logic [BURST_W-1:0] cbs_q  [FLOWS];
  logic [BURST_W-1:0] pbs_q  [FLOWS];
  logic [TOK_W-1:0]   ctok_q [FLOWS];
  logic [TOK_W-1:0]   ptok_q [FLOWS];
  logic [TS_W-1:0]    ts_q   [FLOWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FLOWS; i++) begin
        cir_q[i]  <= '0;
        pir_q[i]  <= '0;
        cbs_q[i]  <= '0;
        pbs_q[i]  <= '0;
        ctok_q[i] <= '0;
        ptok_q[i] <= '0;
        ts_q[i]   <= '0;
      end
    end else begin
      if (wb_en && !(cfg_we && cfg_flow == wb_flow)) begin
        ctok_q[wb_flow] <= wb_ctok;
        ptok_q[wb_flow] <= wb_ptok;
        ts_q[wb_flow]   <= wb_ts;
      end
      if (cfg_we) begin
        cir_q[cfg_flow]  <= cfg_cir;
        pir_q[cfg_flow]  <= cfg_pir;
        cbs_q[cfg_flow]  <= cfg_cbs;
        pbs_q[cfg_flow]  <= cfg_pbs;
        ctok_q[cfg_flow] <= {cfg_cbs, {FRAC_W{1'b0}}};
        ptok_q[cfg_flow] <= {cfg_pbs, {FRAC_W{1'b0}}};
        ts_q[cfg_flow]   <= cfg_now;
      end
    end
  end

  assign rd_cir  = cir_q[rd_flow];
  assign rd_pir  = pir_q[rd_flow];
  assign rd_cbs  = cbs_q[rd_flow];
  assign rd_pbs  = pbs_q[rd_flow];
  assign rd_ctok = ctok_q[rd_flow];
  assign rd_ptok = ptok_q[rd_flow];
  assign rd_ts   = ts_q[rd_flow];
endmodule

// File: rtl/tcm_policer.sv
module tcm_policer import tcm_pkg::*; #(
  parameter int FLOWS   = 16,
  parameter int LEN_W   = 16,
  parameter int TS_W    = 16,
  parameter int RATE_W  = 16,
  parameter int BURST_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TS_W-1:0]          now,
  input  logic                     pkt_valid,
  output logic                     pkt_ready,
  input  logic [$clog2(FLOWS)-1:0] pkt_flow,
  input  logic [LEN_W-1:0]         pkt_len,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [$clog2(FLOWS)-1:0] res_flow,
  output logic [1:0]               res_color,
  output logic [1:0]               res_action,
  input  logic                     cfg_we,
  input  logic [$clog2(FLOWS)-1:0] cfg_flow,
  input  logic [RATE_W-1:0]        cfg_cir,
  input  logic [RATE_W-1:0]        cfg_pir,
  input  logic [BURST_W-1:0]       cfg_cbs,
  input  logic [BURST_W-1:0]       cfg_pbs
);
  localparam int FLOW_W = $clog2(FLOWS);
  localparam int TOK_W  = BURST_W + FRAC_W;

  // table read port
  logic [RATE_W-1:0]  rd_cir, rd_pir;
  logic [BURST_W-1:0] rd_cbs, rd_pbs;
  logic [TOK_W-1:0]   rd_ctok, rd_ptok;
  logic [TS_W-1:0]    rd_ts;

  // stage 1: accepted packet and its flow state
  logic               s1_v;
  logic [FLOW_W-1:0]  s1_flow;
  logic [LEN_W-1:0]   s1_len;
  logic [TS_W-1:0]    s1_ts;
  logic [RATE_W-1:0]  s1_cir, s1_pir;
  logic [BURST_W-1:0] s1_cbs, s1_pbs;
  logic [TOK_W-1:0]   s1_ctok, s1_ptok;
  logic [TS_W-1:0]    s1_last;

  // stage 2: refill, classify, write back
  logic [TS_W-1:0]    elapsed;
  logic [RATE_W-1:0]  bk_rate  [NBKT];
  logic [BURST_W-1:0] bk_burst [NBKT];
  logic [TOK_W-1:0]   bk_tok   [NBKT];
  logic [TOK_W-1:0]   bk_fill  [NBKT];
  color_e             cls_color;
  action_e            cls_action;
  logic [TOK_W-1:0]   wb_ctok, wb_ptok;
  logic               wb_en;

  logic adv, acc, fwd;

  assign adv       = !res_valid || res_ready;
  assign pkt_ready = adv;
  assign acc       = pkt_valid && adv;
  assign wb_en     = s1_v && adv;
  // the packet in stage 1 writes the flow this same edge: take its result
  assign fwd       = wb_en && (s1_flow == pkt_flow);

  tcm_flow_table #(
    .FLOWS(FLOWS), .RATE_W(RATE_W), .BURST_W(BURST_W), .TS_W(TS_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_flow (cfg_flow),
    .cfg_cir  (cfg_cir),
    .cfg_pir  (cfg_pir),
    .cfg_cbs  (cfg_cbs),
    .cfg_pbs  (cfg_pbs),
    .cfg_now  (now),
    .wb_en    (wb_en),
    .wb_flow  (s1_flow),
    .wb_ctok  (wb_ctok),
    .wb_ptok  (wb_ptok),
    .wb_ts    (s1_ts),
    .rd_flow  (pkt_flow),
    .rd_cir   (rd_cir),
    .rd_pir   (rd_pir),
    .rd_cbs   (rd_cbs),
    .rd_pbs   (rd_pbs),
    .rd_ctok  (rd_ctok),
    .rd_ptok  (rd_ptok),
    .rd_ts    (rd_ts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_flow <= '0;
      s1_len  <= '0;
      s1_ts   <= '0;
      s1_cir  <= '0;
      s1_pir  <= '0;
      s1_cbs  <= '0;
      s1_pbs  <= '0;
      s1_ctok <= '0;
      s1_ptok <= '0;
      s1_last <= '0;
    end else if (adv) begin
      s1_v <= acc;
      if (acc) begin
        s1_flow <= pkt_flow;
        s1_len  <= pkt_len;
        s1_ts   <= now;
        if (fwd) begin
          s1_ctok <= wb_ctok;
          s1_ptok <= wb_ptok;
          s1_last <= s1_ts;
        end else begin
          s1_cir  <= rd_cir;
          s1_pir  <= rd_pir;
          s1_cbs  <= rd_cbs;
          s1_pbs  <= rd_pbs;
          s1_ctok <= rd_ctok;
          s1_ptok <= rd_ptok;
          s1_last <= rd_ts;
        end
      end
    end
  end

  assign elapsed = s1_ts - s1_last;

  assign bk_rate[BK_C]  = s1_cir;
  assign bk_rate[BK_P]  = s1_pir;
  assign bk_burst[BK_C] = s1_cbs;
  assign bk_burst[BK_P] = s1_pbs;
  assign bk_tok[BK_C]   = s1_ctok;
  assign bk_tok[BK_P]   = s1_ptok;

  for (genvar b = 0; b < NBKT; b++) begin : g_bucket
    tcm_refill #(
      .TS_W(TS_W), .RATE_W(RATE_W), .BURST_W(BURST_W)
    ) u_refill (
      .tok     (bk_tok[b]),
      .burst   (bk_burst[b]),
      .rate    (bk_rate[b]),
      .elapsed (elapsed),
      .tok_new (bk_fill[b])
    );
  end

  tcm_classify #(
    .BURST_W(BURST_W), .LEN_W(LEN_W)
  ) u_classify (
    .ctok     (bk_fill[BK_C]),
    .ptok     (bk_fill[BK_P]),
    .len      (s1_len),
    .color    (cls_color),
    .action   (cls_action),
    .ctok_out (wb_ctok),
    .ptok_out (wb_ptok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_flow   <= '0;
      res_color  <= COL_GREEN;
      res_action <= ACT_PASS;
    end else if (adv) begin
      res_valid <= s1_v;
      if (s1_v) begin
        res_flow   <= s1_flow;
        res_color  <= cls_color;
        res_action <= cls_action;
      end
    end
  end
endmodule

// File: rtl/tcm_policer_checker.sv
module tcm_policer_checker #(
  parameter int FLOW_W  = 4,
  parameter int BURST_W = 20,
  parameter int TOK_W   = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [FLOW_W-1:0] res_flow,
  input logic [1:0]        res_color,
  input logic [1:0]        res_action,
  input logic              s1_v,
  input logic              wb_en,
  input logic [TOK_W-1:0]  wb_ctok,
  input logic [TOK_W-1:0]  wb_ptok,
  input logic [BURST_W-1:0] s1_cbs,
  input logic [BURST_W-1:0] s1_pbs
);
  localparam int FR = TOK_W - BURST_W;

  a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_color)
      && $stable(res_action) && $stable(res_flow));

  a_r3_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !pkt_ready);

  a_r2_result_has_packet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(s1_v));

  // R4 R5 R6: colour and action travel as a legal pair
  a_r6_color_action_pair: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_color != 2'd3) && (res_action == res_color));

  a_r8_ctok_capped: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_ctok <= {s1_cbs, {FR{1'b0}}});

  a_r8_ptok_capped: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_ptok <= {s1_pbs, {FR{1'b0}}});
endmodule

bind tcm_policer tcm_policer_checker #(
  .FLOW_W(FLOW_W), .BURST_W(BURST_W), .TOK_W(TOK_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_ready  (pkt_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_flow   (res_flow),
  .res_color  (res_color),
  .res_action (res_action),
  .s1_v       (s1_v),
  .wb_en      (wb_en),
  .wb_ctok    (wb_ctok),
  .wb_ptok    (wb_ptok),
  .s1_cbs     (s1_cbs),
  .s1_pbs     (s1_pbs)
);

// File: tb/tcm_policer_tb.sv
`timescale 1ns/1ps
module tcm_policer_tb;
  localparam int GRN = 0, YEL = 1, RED = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] now = '0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [3:0]  pkt_flow = '0;
  logic [15:0] pkt_len = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [3:0]  res_flow;
  logic [1:0]  res_color;
  logic [1:0]  res_action;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_flow = '0;
  logic [15:0] cfg_cir = '0;
  logic [15:0] cfg_pir = '0;
  logic [19:0] cfg_cbs = '0;
  logic [19:0] cfg_pbs = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tcm_policer u_dut (
    .clk(clk), .rst_n(rst_n), .now(now),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_flow(pkt_flow), .pkt_len(pkt_len),
    .res_valid(res_valid), .res_ready(res_ready), .res_flow(res_flow),
    .res_color(res_color), .res_action(res_action),
    .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_cir(cfg_cir), .cfg_pir(cfg_pir),
    .cfg_cbs(cfg_cbs), .cfg_pbs(cfg_pbs)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // check the result currently on the output against an expected colour
  task automatic check_res(input string req, input int flow, input int col);
    check(req, "res_valid", int'(res_valid), 1);
    check(req, "res_flow", int'(res_flow), flow);
    check(req, "res_color", int'(res_color), col);
    check(req, "res_action", int'(res_action), col);
  endtask

  // every task starts and ends just after a falling edge
  task automatic do_cfg(input int flow, input int cir, input int pir,
                        input int cbs, input int pbs, input int t);
    now      = 16'(t);
    cfg_flow = 4'(flow);
    cfg_cir  = 16'(cir);
    cfg_pir  = 16'(pir);
    cfg_cbs  = 20'(cbs);
    cfg_pbs  = 20'(pbs);
    cfg_we   = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int flow, input int len, input int t,
                      input int col, input string req);
    now       = 16'(t);
    pkt_flow  = 4'(flow);
    pkt_len   = 16'(len);
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    @(negedge clk);
    check_res(req, flow, col);
  endtask

  task automatic t_reset;
    check("R1", "res_valid after reset", int'(res_valid), 0);
    check("R1", "pkt_ready after reset", int'(pkt_ready), 1);
    send(7, 1, 0, RED, "R1");
    send(7, 0, 0, GRN, "R1");
  endtask

  task automatic t_classify;
    do_cfg(1, 0, 0, 100, 200, 10);
    send(1, 60, 10, GRN, "R6");   // C 40 P 140
    send(1, 60, 10, YEL, "R5");   // C 40 P 80
    send(1, 90, 10, RED, "R4");   // no debit
    send(1, 80, 10, YEL, "R4");   // proves peak kept 80; P 0
    send(1, 0, 10, GRN, "R6");
    send(1, 40, 10, RED, "R5");   // peak debited earlier
    send(1, 40, 10, RED, "R12");
    do_cfg(1, 0, 0, 100, 200, 20);
    send(1, 100, 20, GRN, "R10"); // refilled by configuration
    send(1, 100, 20, YEL, "R10"); // C 0 P 100
  endtask

  task automatic t_refill;
    do_cfg(2, 16'h0200, 16'h0400, 100, 100, 100);
    send(2, 100, 100, GRN, "R7");
    send(2, 30, 110, YEL, "R7");  // C 20 P 40 -> P 10
    send(2, 20, 115, GRN, "R7");  // C 30 P 30
    do_cfg(3, 16'h0180, 16'h0180, 1000, 1000, 0);
    send(3, 1000, 0, GRN, "R7");
    send(3, 5, 3, RED, "R7");     // 4.5 tokens
    send(3, 5, 4, GRN, "R7");     // 6.0 tokens
    send(3, 2, 4, RED, "R7");     // 1.0 tokens left
  endtask

  task automatic t_saturate_wrap;
    do_cfg(4, 16'h0100, 16'h0100, 50, 80, 1000);
    send(4, 80, 1000, YEL, "R8");   // P 0
    send(4, 81, 61000, RED, "R8");  // P capped at 80
    send(4, 51, 61000, YEL, "R8");  // C capped at 50; P 29
    send(4, 80, 5464, YEL, "R9");   // wrapped gap of 10000 ticks
    send(4, 1, 5464, RED, "R9");
  endtask

  task automatic t_back_to_back;
    do_cfg(5, 0, 0, 100, 100, 0);
    now       = 16'd0;
    pkt_flow  = 4'd5;
    pkt_len   = 16'd70;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_len = 16'd30;
    @(negedge clk);
    pkt_len = 16'd1;
    check_res("R11", 5, GRN);
    @(negedge clk);
    pkt_valid = 1'b0;
    check_res("R11", 5, GRN);
    @(negedge clk);
    check_res("R2", 5, RED);
    @(negedge clk);
    check("R2", "res_valid after drain", int'(res_valid), 0);
  endtask

  task automatic t_backpressure;
    do_cfg(6, 0, 0, 100, 100, 0);
    res_ready = 1'b0;
    now       = 16'd0;
    pkt_flow  = 4'd6;
    pkt_len   = 16'd10;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_len = 16'd95;
    @(negedge clk);
    pkt_valid = 1'b0;
    check_res("R3", 6, GRN);
    check("R3", "pkt_ready while stalled", int'(pkt_ready), 0);
    @(negedge clk);
    check_res("R3", 6, GRN);
    check("R3", "pkt_ready still stalled", int'(pkt_ready), 0);
    res_ready = 1'b1;
    @(negedge clk);
    check_res("R2", 6, RED);       // C 90 P 90 < 95
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_refill();
    t_saturate_wrap();
    t_back_to_back();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule